// File: doc/BRIEF.md
# Multi-Rail Power-Good Combiner with Timed Blanking

This block merges the window-comparator verdicts of three regulated rails into one open-drain power-good signal. Each rail reports an above-window flag and a below-window flag. It also reports whether its reference DAC is slewing, whether that slew moves downward, and whether the DAC is switched off. The block combines these with a global enable, a host power-good-in level, a startup-phase flag and a 1 µs tick. From them it produces two mutually exclusive registered outputs: drive the pin low, or float it because the pin is blanked. When neither is asserted, the pin is released high. A single-cycle pulse marks each release, and the surrounding logic can use it to capture the boot code.

Forcing conditions take priority over blanking, and blanking takes priority over rail faults. The forcing conditions are: enable low, every DAC off, the startup hold, and the hold after a falling power-good-in. A DAC slew holds the blanking on, and a 20-tick timer keeps it on after the slew ends. After a downward slew, a rail ignores its above-window flag until that rail is back inside its window.

Top module: `pgb_top`

## Requirements
- R1: During reset and on the first cycle after it, pg_low_o=1, pg_hiz_o=0 and pg_rise_o=0.
- R2: With en_i low at a clock edge, pg_low_o=1 and pg_hiz_o=0 after that edge, even while a DAC is slewing.
- R3: With no forcing or blanking active, a below-window flag, or an unmasked above-window flag, on any rail that is not off makes pg_low_o=1 after the next edge.
- R4: While any rail that is not off has slew_i=1, and until HOLD_US ticks after the last such cycle, pg_hiz_o=1 unless a forcing condition holds.
- R5: A rail slewing with down_i=1 ignores its ov_i until it is seen with ov_i=0 and uv_i=0 while not slewing; its uv_i still counts meanwhile.
- R6: A rail with off_i=1 contributes no fault and counts as inside its window.
- R7: When every rail has off_i=1, pg_low_o=1.
- R8: While startup_i=1, pg_low_o=1 until HOLD_US ticks after all rails are inside their windows.
- R9: A high-to-low change of pgd_in_i forces pg_low_o=1 for at least HOLD_US ticks, and then until all rails are inside their windows.
- R10: Each hold timer reloads to HOLD_US whenever its trigger recurs, so the hold is measured from the last trigger.
- R11: pg_low_o and pg_hiz_o are never both 1. pg_rise_o is 1 for exactly one cycle, on the first cycle in which both are 0 after a cycle in which either was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; low forces the pin low |
| pgd_in_i | input | 1 | Host power-good-in level |
| startup_i | input | 1 | Startup phase in progress |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| ov_i | input | NUM_RAILS | Per-rail above-window flag |
| uv_i | input | NUM_RAILS | Per-rail below-window flag |
| slew_i | input | NUM_RAILS | Per-rail DAC slewing |
| down_i | input | NUM_RAILS | Per-rail slew direction, 1 = downward |
| off_i | input | NUM_RAILS | Per-rail DAC in off mode |
| pg_low_o | output | 1 | Drive the open-drain pin low |
| pg_hiz_o | output | 1 | Pin blanked (floated) |
| pg_rise_o | output | 1 | One-cycle pulse when the pin is released |

## Verification
A rail fault and DAC blanking can occur in the same cycle. The bench provokes this by raising an above-window flag during a downward slew and keeping it up after the slew ends. It expects a float, not a drive low, while the blanking lasts, and a released pin once the blanking timer has expired while the masked flag is still up. The enable and an active slew are also made to collide. In that case the bench expects the drive-low output to win and the float output to clear on the next edge.

// File: rtl/pgb_pkg.sv
`timescale 1ns/1ps
package pgb_pkg;
    typedef struct packed {
        logic low;
        logic hiz;
        logic rise;
        logic pgd_prev;
        logic pgd_hold;
    } pgb_state_t;

    localparam pgb_state_t PGB_RESET = '{low: 1'b1, hiz: 1'b0, rise: 1'b0,
                                         pgd_prev: 1'b0, pgd_hold: 1'b0};
endpackage

// File: rtl/pgb_hold_timer.sv
`timescale 1ns/1ps
module pgb_hold_timer #(
    parameter int HOLD_US = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic trig_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(HOLD_US + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_US);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig_i)
            cnt_d = LOAD;
        else if (tick_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = trig_i | (cnt_q != '0);

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (busy_o && cnt_q == LOAD));
endmodule

// File: rtl/pgb_rail.sv
`timescale 1ns/1ps
module pgb_rail (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ov_i,
    input  logic uv_i,
    input  logic slew_i,
    input  logic down_i,
    input  logic off_i,
    output logic fault_o,
    output logic in_win_o
);
    logic mask_d, mask_q;
    logic ov_masked;

    always_comb begin
        mask_d = mask_q;
        if (!en_i || off_i)
            mask_d = 1'b0;
        else if (slew_i && down_i)
            mask_d = 1'b1;
        else if (!slew_i && !ov_i && !uv_i)
            mask_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= 1'b0;
        else        mask_q <= mask_d;
    end

    assign ov_masked = mask_q | (slew_i & down_i);
    assign fault_o   = ~off_i & (uv_i | (ov_i & ~ov_masked));
    assign in_win_o  = off_i | (~ov_i & ~uv_i);

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && en_i && !off_i && (ov_i || uv_i)) |=> mask_q);
endmodule

// File: rtl/pgb_top.sv
`timescale 1ns/1ps
module pgb_top #(
    parameter int NUM_RAILS = 3,
    parameter int HOLD_US   = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 pgd_in_i,
    input  logic                 startup_i,
    input  logic                 tick_us_i,
    input  logic [NUM_RAILS-1:0] ov_i,
    input  logic [NUM_RAILS-1:0] uv_i,
    input  logic [NUM_RAILS-1:0] slew_i,
    input  logic [NUM_RAILS-1:0] down_i,
    input  logic [NUM_RAILS-1:0] off_i,
    output logic                 pg_low_o,
    output logic                 pg_hiz_o,
    output logic                 pg_rise_o
);
    import pgb_pkg::*;

    logic [NUM_RAILS-1:0] rail_fault, rail_win;
    logic fault_any, all_win, all_off, slew_any;
    logic blank_busy, start_busy, pgd_busy;
    logic pgd_fall, start_trig, start_low, force_low_d;
    pgb_state_t st_d, st_q;

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        pgb_rail u_rail (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .ov_i    (ov_i[g]),
            .uv_i    (uv_i[g]),
            .slew_i  (slew_i[g]),
            .down_i  (down_i[g]),
            .off_i   (off_i[g]),
            .fault_o (rail_fault[g]),
            .in_win_o(rail_win[g])
        );
    end

    assign fault_any  = |rail_fault;
    assign all_win    = &rail_win;
    assign all_off    = &off_i;
    assign slew_any   = |(slew_i & ~off_i);
    assign pgd_fall   = en_i & st_q.pgd_prev & ~pgd_in_i;
    assign start_trig = startup_i & ~all_win;

    pgb_hold_timer #(.HOLD_US(HOLD_US)) u_blank_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us_i),
        .trig_i(slew_any), .busy_o(blank_busy));

    pgb_hold_timer #(.HOLD_US(HOLD_US)) u_start_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us_i),
        .trig_i(start_trig), .busy_o(start_busy));

    pgb_hold_timer #(.HOLD_US(HOLD_US)) u_pgd_tmr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_us_i),
        .trig_i(pgd_fall), .busy_o(pgd_busy));

    assign start_low = startup_i & start_busy;

    always_comb begin
        st_d          = st_q;
        st_d.pgd_prev = pgd_in_i;
        if (!en_i)
            st_d.pgd_hold = 1'b0;
        else if (pgd_fall)
            st_d.pgd_hold = 1'b1;
        else if (!pgd_busy && all_win)
            st_d.pgd_hold = 1'b0;

        force_low_d = ~en_i | all_off | start_low | st_d.pgd_hold;
        st_d.low    = force_low_d | (~blank_busy & fault_any);
        st_d.hiz    = ~force_low_d & blank_busy;
        st_d.rise   = ~st_d.low & ~st_d.hiz & (st_q.low | st_q.hiz);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PGB_RESET;
        else        st_q <= st_d;
    end

    assign pg_low_o  = st_q.low;
    assign pg_hiz_o  = st_q.hiz;
    assign pg_rise_o = st_q.rise;

    // R2
    disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pg_low_o && !pg_hiz_o));

    // R7
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && all_off) |=> pg_low_o);

    // R9
    pgd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgd_fall |=> pg_low_o);

    // R3
    fault_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && fault_any && !blank_busy) |=> pg_low_o);

    // R4
    blank_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slew_any && !force_low_d) |=> pg_hiz_o);

    // R11
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pg_low_o && pg_hiz_o));

    // R11
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_rise_o |-> (!pg_low_o && !pg_hiz_o && ($past(pg_low_o) || $past(pg_hiz_o))));
endmodule

// File: tb/pgb_top_tb_top.sv
`timescale 1ns/1ps
module pgb_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, pgd = 1'b0, startup = 1'b0, tick = 1'b0;
    logic [2:0] ov = '0, uv = '0, slew = '0, dn = '0, off = '0;
    logic pg_low, pg_hiz, pg_rise;
    int checks = 0;
    int failures = 0;
    int tick_div = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tick_div = (tick_div == 3) ? 0 : tick_div + 1;
        tick = (tick_div == 0);
    end

    pgb_top dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .pgd_in_i(pgd),
        .startup_i(startup), .tick_us_i(tick),
        .ov_i(ov), .uv_i(uv), .slew_i(slew), .down_i(dn), .off_i(off),
        .pg_low_o(pg_low), .pg_hiz_o(pg_hiz), .pg_rise_o(pg_rise));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) @(posedge clk iff tick);
        cyc(2);
    endtask

    task automatic setup_clean();
        rst_n = 1'b0; en = 1'b1; pgd = 1'b1; startup = 1'b0;
        ov = '0; uv = '0; slew = '0; dn = '0; off = '0;
        cyc(2);
        rst_n = 1'b1;
        cyc(3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b1; pgd = 1'b1;
        cyc(2);
        chk("R1 low in reset", pg_low, 1'b1);
        chk("R1 hiz in reset", pg_hiz, 1'b0);
        chk("R1 rise in reset", pg_rise, 1'b0);
        rst_n = 1'b1;
        cyc(3);
        chk("R11 released when clean", pg_low | pg_hiz, 1'b0);
    endtask

    task automatic t_startup();
        rst_n = 1'b0; en = 1'b1; pgd = 1'b0; startup = 1'b1; uv = 3'b111;
        cyc(2);
        rst_n = 1'b1;
        cyc(5);
        chk("R8 low before regulation", pg_low, 1'b1);
        uv = '0;
        wait_ticks(19);
        chk("R8 still low inside hold", pg_low, 1'b1);
        for (int i = 0; i < 40 && pg_low; i++) cyc(1);
        chk("R8 released after hold", pg_low, 1'b0);
        chk("R11 rise pulse on release", pg_rise, 1'b1);
        cyc(1);
        chk("R11 rise pulse one cycle", pg_rise, 1'b0);
        startup = 1'b0;
    endtask

    task automatic t_faults();
        setup_clean();
        uv[1] = 1'b1; cyc(2);
        chk("R3 under-window low", pg_low, 1'b1);
        uv[1] = 1'b0; ov[2] = 1'b1; cyc(2);
        chk("R3 over-window low", pg_low, 1'b1);
        ov[2] = 1'b0; uv[1] = 1'b1; off[1] = 1'b1; cyc(2);
        chk("R6 off rail excluded", pg_low, 1'b0);
        off = 3'b111; cyc(2);
        chk("R7 all off low", pg_low, 1'b1);
        chk("R11 no hiz with low", pg_hiz, 1'b0);
        off = '0; uv = '0; cyc(3);
    endtask

    task automatic t_blank();
        setup_clean();
        slew[0] = 1'b1; dn[0] = 1'b0; cyc(5);
        chk("R4 hiz while slewing", pg_hiz, 1'b1);
        slew[0] = 1'b0;
        wait_ticks(19);
        chk("R4 hiz held after slew", pg_hiz, 1'b1);
        wait_ticks(3);
        chk("R4 hiz released", pg_hiz, 1'b0);
        chk("R4 not low after blank", pg_low, 1'b0);
    endtask

    task automatic t_restart();
        setup_clean();
        slew[2] = 1'b1; cyc(3); slew[2] = 1'b0;
        wait_ticks(10);
        slew[2] = 1'b1; cyc(1); slew[2] = 1'b0;
        wait_ticks(15);
        chk("R10 hold restarted", pg_hiz, 1'b1);
        wait_ticks(7);
        chk("R10 restarted hold expires", pg_hiz, 1'b0);
    endtask

    task automatic t_down_mask();
        setup_clean();
        slew[0] = 1'b1; dn[0] = 1'b1; ov[0] = 1'b1; cyc(4);
        chk("R5 fault blanked during slew", pg_hiz, 1'b1);
        slew[0] = 1'b0;
        wait_ticks(22);
        chk("R5 over masked after down slew", pg_low, 1'b0);
        chk("R5 released after blanking", pg_hiz, 1'b0);
        uv[0] = 1'b1; cyc(2);
        chk("R5 under still counts", pg_low, 1'b1);
        uv[0] = 1'b0; ov[0] = 1'b0; dn[0] = 1'b0; cyc(2);
        ov[0] = 1'b1; cyc(2);
        chk("R5 mask cleared after regulation", pg_low, 1'b1);
        ov[0] = 1'b0; cyc(2);
    endtask

    task automatic t_enable();
        setup_clean();
        slew[1] = 1'b1; cyc(3);
        en = 1'b0; cyc(1);
        chk("R2 disable forces low", pg_low, 1'b1);
        chk("R2 disable clears hiz", pg_hiz, 1'b0);
        en = 1'b1; slew[1] = 1'b0;
        wait_ticks(22);
    endtask

    task automatic t_pgd();
        setup_clean();
        pgd = 1'b0; cyc(2);
        chk("R9 low on falling pgd", pg_low, 1'b1);
        uv[2] = 1'b1;
        wait_ticks(19);
        chk("R9 low during hold", pg_low, 1'b1);
        wait_ticks(4);
        chk("R9 low until in window", pg_low, 1'b1);
        uv[2] = 1'b0; cyc(3);
        chk("R9 released in window", pg_low, 1'b0);
        pgd = 1'b1; cyc(3);
        chk("R9 rising pgd no effect", pg_low, 1'b0);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_faults();
        t_blank();
        t_restart();
        t_down_mask();
        t_enable();
        t_pgd();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule